// File: doc/BRIEF.md
# Compare-Match Timer with Programmable Period

This block is a 10-bit up-counting timer with two comparators. Comparator A checks the count against a full-width compare value, and comparator P checks the count against a coarse period. Software reaches the block through a byte-wide register interface. Reads return their data combinationally, and writes take effect on the clock edge.

In compare mode, a clear-select bit chooses which comparator restarts the count. The choice also controls which of the two sticky interrupt flags can be raised. An A event drives the output pin through a programmable action. Pulse-width and plain-timer modes have their mode codes decoded, and each has a simple placeholder behaviour.

The compare value is written in two byte halves. The low half is staged and commits together with the high half, so the comparator never sees a half-updated value.

Top module: `cmp_timer`

## Requirements
- R1: After reset, every readable register, the counter, the compare value, both flags and the output pin are zero.
- R2: The register map is addressed by the read and write address. The addresses are:
  - 0: control0, with bit 0 the run enable and bits 3:1 the period.
  - 1: control1, with bits 1:0 the mode, bits 3:2 the match action, bit 4 the init level and bit 5 the clear select.
  - 2: count bits 7:0.
  - 3: count bits 9:8, in data bits 1:0.
  - 4: compare A bits 7:0.
  - 5: compare A bits 9:8.
  - 6: flags, with bit 0 the A flag and bit 1 the P flag.
  - 7: reads zero.

  Unused bits read zero, and writes to addresses 2, 3 and 7 change nothing.
- R3: A write to address 4 is staged. The compare value, and the data read back at address 4, change only when address 5 is written. That write loads the high bits from data bits 1:0 together with the staged low byte.
- R4: While run enable is 0, the count is held at 0 and the output pin equals the init level.
- R5: In compare mode (mode 0), with clear select 0 and a nonzero period p, the count goes from p*128 to 0. The P flag is set in the cycle after the count equals p*128.
- R6: In compare mode with clear select 0 and period 0, the count wraps from 0x3FF to 0, and the P flag is set after the count equals 0x3FF.
- R7: In compare mode with clear select 0, the A flag is set after the count equals the compare value. A and P events can fall in the same cycle.
- R8: In compare mode with clear select 1, the count goes to 0 after it equals a nonzero compare value, and the A flag is set. The P flag is never set, even when p*128 is below the compare value.
- R9: With clear select 1 and a compare value of 0, the count wraps after 0x3FF and no A flag is raised.
- R10: In compare mode, the output pin changes only in the cycle after an A event. The match action codes are 0 = keep, 1 = low, 2 = high and 3 = toggle.
- R11: The flags are sticky. Writing 0 to a flag bit at address 6 clears it, and writing 1 leaves it unchanged. A new event in the same cycle wins over the clear.
- R12: In modes 1 to 3, no flags are raised and the count wraps at 0x3FF. In mode 1, the pin follows (count < compare value) one cycle late. In modes 2 and 3, the pin equals the init level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 8 | Register read data, combinational |
| irqA | output | 1 | Sticky comparator A flag |
| irqP | output | 1 | Sticky comparator P flag |
| outPin | output | 1 | Timer output pin |

## Verification
Two collisions can happen in the same cycle: an A event with a P event, and a flag event with a software write that clears the flag. For the first, the compare value is set to exactly p*128 with clear select 0. Both flags must then rise in the same cycle, and the count must return to zero. For the second, the random phase issues flag-clear writes at arbitrary cycles while events occur. Each cycle is judged against a bench model in which the event wins over the clear.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  typedef enum logic [2:0] {
    ADR_CTRL0  = 3'd0,
    ADR_CTRL1  = 3'd1,
    ADR_CNT_LO = 3'd2,
    ADR_CNT_HI = 3'd3,
    ADR_CMP_LO = 3'd4,
    ADR_CMP_HI = 3'd5,
    ADR_FLAGS  = 3'd6
  } regAddr_e;

  typedef enum logic [1:0] {
    MODE_CMP = 2'd0,
    MODE_PWM = 2'd1,
    MODE_TMR = 2'd2,
    MODE_RSV = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } matchAct_e;

  // strobes from control to datapath
  typedef struct packed {
    logic hold;
    logic clear;
  } cntStrobe_t;

endpackage

// File: rtl/cmp_timer_dp.sv
module cmp_timer_dp
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int PER_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strb,
  input  logic [CNT_W-1:0] ccra,
  input  logic [PER_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             eqA,
  output logic             eqP,
  output logic             atMax
);

  localparam int LOW_W = CNT_W - PER_W;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (strb.hold)  cnt <= '0;
    else if (strb.clear) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign eqA   = (cnt == ccra);
  assign eqP   = (cnt == {period, {LOW_W{1'b0}}});
  assign atMax = &cnt;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.hold && !strb.clear) |=> (cnt == $past(cnt) + 1'b1)); // R12

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (cnt == '0)); // R5

endmodule

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int PER_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              eqA,
  input  logic              eqP,
  input  logic              atMax,
  output cntStrobe_t        strb,
  output logic [CNT_W-1:0]  ccra,
  output logic [PER_W-1:0]  period,
  output logic              flagA,
  output logic              flagP,
  output logic              outPin
);

  localparam int HI_W = CNT_W - DATA_W;

  logic              runBit, initLvl, clrSel;
  mode_e             mode;
  matchAct_e         action;
  logic [DATA_W-1:0] loBuf;
  logic              isCmp, pHit, aEv, pEv, clrFlagA, clrFlagP;

  // register writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit  <= 1'b0;
      period  <= '0;
      mode    <= MODE_CMP;
      action  <= ACT_KEEP;
      initLvl <= 1'b0;
      clrSel  <= 1'b0;
      loBuf   <= '0;
      ccra    <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADR_CTRL0: begin
          runBit <= wrData[0];
          period <= wrData[PER_W:1];
        end
        ADR_CTRL1: begin
          mode    <= mode_e'(wrData[1:0]);
          action  <= matchAct_e'(wrData[3:2]);
          initLvl <= wrData[4];
          clrSel  <= wrData[5];
        end
        ADR_CMP_LO: loBuf <= wrData;
        ADR_CMP_HI: ccra  <= {wrData[HI_W-1:0], loBuf};
        default: ;
      endcase
    end
  end

  // event decode
  always_comb begin
    isCmp = (mode == MODE_CMP);
    pHit  = (period == '0) ? atMax : eqP;
    aEv   = 1'b0;
    pEv   = 1'b0;
    strb.clear = 1'b0;
    if (runBit && isCmp) begin
      if (!clrSel) begin
        pEv        = pHit;
        aEv        = eqA;
        strb.clear = pHit && (period != '0);
      end else begin
        aEv        = eqA && (ccra != '0);
        strb.clear = aEv;
      end
    end
    strb.hold = !runBit;
  end

  // sticky flags, event wins over software clear
  assign clrFlagA = wrEn && (wrAddr == ADR_FLAGS) && !wrData[0];
  assign clrFlagP = wrEn && (wrAddr == ADR_FLAGS) && !wrData[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagA <= 1'b0;
      flagP <= 1'b0;
    end else begin
      flagA <= aEv || (flagA && !clrFlagA);
      flagP <= pEv || (flagP && !clrFlagP);
    end
  end

  // output pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outPin <= 1'b0;
    else if (!runBit) outPin <= initLvl;
    else begin
      case (mode)
        MODE_CMP: begin
          if (aEv) begin
            case (action)
              ACT_LOW:    outPin <= 1'b0;
              ACT_HIGH:   outPin <= 1'b1;
              ACT_TOGGLE: outPin <= !outPin;
              default:    ;
            endcase
          end
        end
        MODE_PWM: outPin <= (cnt < ccra);
        default:  outPin <= initLvl;
      endcase
    end
  end

  // read mux
  always_comb begin
    case (rdAddr)
      ADR_CTRL0:  rdData = DATA_W'({period, runBit});
      ADR_CTRL1:  rdData = DATA_W'({clrSel, initLvl, action, mode});
      ADR_CNT_LO: rdData = cnt[DATA_W-1:0];
      ADR_CNT_HI: rdData = DATA_W'(cnt[CNT_W-1:DATA_W]);
      ADR_CMP_LO: rdData = ccra[DATA_W-1:0];
      ADR_CMP_HI: rdData = DATA_W'(ccra[CNT_W-1:DATA_W]);
      ADR_FLAGS:  rdData = DATA_W'({flagP, flagA});
      default:    rdData = '0;
    endcase
  end

  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !runBit |=> (cnt == '0)); // R4

  AST_P_NEVER: assert property (@(posedge clk) disable iff (!rstN)
    (clrSel && !flagP) |=> !flagP); // R8

  AST_ZERO_CCRA: assert property (@(posedge clk) disable iff (!rstN)
    (clrSel && (ccra == '0) && !flagA) |=> !flagA); // R9

  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (runBit && isCmp && !aEv) |=> $stable(outPin)); // R10

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (clrFlagA && !aEv) |=> !flagA); // R11

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int PER_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irqA,
  output logic              irqP,
  output logic              outPin
);

  cntStrobe_t       strb;
  logic [CNT_W-1:0] cnt, ccra;
  logic [PER_W-1:0] period;
  logic             eqA, eqP, atMax;

  cmp_timer_ctrl #(.CNT_W(CNT_W), .PER_W(PER_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .cnt(cnt), .eqA(eqA), .eqP(eqP),
    .atMax(atMax), .strb(strb), .ccra(ccra), .period(period),
    .flagA(irqA), .flagP(irqP), .outPin(outPin)
  );

  cmp_timer_dp #(.CNT_W(CNT_W), .PER_W(PER_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ccra(ccra), .period(period),
    .cnt(cnt), .eqA(eqA), .eqP(eqP), .atMax(atMax)
  );

endmodule

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       irqA, irqP, outPin;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  cmp_timer i_cmp_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irqA(irqA), .irqP(irqP), .outPin(outPin)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model built from the requirements
  logic       mRun, mInit, mClr, mFa, mFp, mPin;
  logic [2:0] mPer;
  logic [1:0] mMode, mAct;
  logic [9:0] mCcra, mCnt;
  logic [7:0] mLo;

  always @(posedge clk) begin
    logic aE, pE, clr, pHit;
    if (!rstN) begin
      mRun <= 0; mInit <= 0; mClr <= 0; mFa <= 0; mFp <= 0; mPin <= 0;
      mPer <= 0; mMode <= 0; mAct <= 0; mCcra <= 0; mCnt <= 0; mLo <= 0;
    end else begin
      pHit = (mPer == 0) ? (mCnt == 10'h3FF) : (mCnt == {mPer, 7'd0});
      aE = 0; pE = 0; clr = 0;
      if (mRun && mMode == 2'd0) begin
        if (!mClr) begin
          pE = pHit; aE = (mCnt == mCcra); clr = pHit && (mPer != 0);
        end else begin
          aE = (mCcra != 0) && (mCnt == mCcra); clr = aE;
        end
      end
      mCnt <= (!mRun || clr) ? 10'd0 : mCnt + 10'd1;
      if (!mRun) mPin <= mInit;
      else if (mMode == 2'd0) begin
        if (aE) case (mAct)
          2'd1: mPin <= 1'b0;
          2'd2: mPin <= 1'b1;
          2'd3: mPin <= ~mPin;
          default: ;
        endcase
      end else if (mMode == 2'd1) mPin <= (mCnt < mCcra);
      else mPin <= mInit;
      mFa <= aE | (mFa & !(wrEn && wrAddr == 3'd6 && !wrData[0]));
      mFp <= pE | (mFp & !(wrEn && wrAddr == 3'd6 && !wrData[1]));
      if (wrEn) case (wrAddr)
        3'd0: begin mRun <= wrData[0]; mPer <= wrData[3:1]; end
        3'd1: begin mMode <= wrData[1:0]; mAct <= wrData[3:2]; mInit <= wrData[4]; mClr <= wrData[5]; end
        3'd4: mLo <= wrData;
        3'd5: mCcra <= {wrData[1:0], mLo};
        default: ;
      endcase
    end
  end

  function automatic logic [7:0] expRd(input logic [2:0] a);
    case (a)
      3'd0: return {4'd0, mPer, mRun};
      3'd1: return {2'd0, mClr, mInit, mAct, mMode};
      3'd2: return mCnt[7:0];
      3'd3: return {6'd0, mCnt[9:8]};
      3'd4: return mCcra[7:0];
      3'd5: return {6'd0, mCcra[9:8]};
      3'd6: return {6'd0, mFp, mFa};
      default: return 8'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    #1;
    chk("R11 irqA", irqA, mFa);
    chk("R11 irqP", irqP, mFp);
    chk("R10 outPin", outPin, mPin);
    chk("R2 rdData", rdData, expRd(rdAddr));
  endtask

  task automatic tick();
    @(negedge clk);
    compareAll();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [2:0] a, input int exp);
    rdAddr = a;
    #1;
    chk(tag, rdData, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nErrors++;
      $display("FAIL WDOG actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    int seed;
    bit hit;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) rdChk("R1 reset reg", 3'(a), 0);
    chk("R1 reset irqA", irqA, 0);
    chk("R1 reset irqP", irqP, 0);
    chk("R1 reset pin", outPin, 0);

    // R2 counter bytes read-only, R3 staged low byte
    wr(3'd2, 8'hFF);
    wr(3'd7, 8'hFF);
    rdChk("R2 cnt ro", 3'd2, 0);
    wr(3'd1, 8'h0C);
    wr(3'd4, 8'h05);
    rdChk("R3 staged", 3'd4, 0);
    wr(3'd5, 8'h00);
    rdChk("R3 commit", 3'd4, 5);

    // R5 / R7 / R10: period 1, compare 5, toggle
    wr(3'd0, 8'h03);
    rdAddr = 3'd2;
    repeat (5) tick();
    chk("R7 cnt5", rdData, 5);
    chk("R7 noflag", irqA, 0);
    tick();
    chk("R7 flagA", irqA, 1);
    chk("R10 toggle", outPin, 1);
    repeat (122) tick();
    chk("R5 cnt128", rdData, 128);
    chk("R5 noP", irqP, 0);
    tick();
    chk("R5 clear", rdData, 0);
    chk("R5 flagP", irqP, 1);

    // R7 simultaneous A and P events
    wr(3'd6, 8'h00);
    wr(3'd4, 8'h80);
    wr(3'd5, 8'h00);
    rdAddr = 3'd2;
    hit = 0;
    for (int i = 0; i < 300 && !hit; i++) begin
      tick();
      hit = irqA | irqP;
    end
    chk("R7 both A", irqA, 1);
    chk("R7 both P", irqP, 1);
    chk("R7 both cnt", rdData, 0);

    // R6 period zero wraps at full scale
    wr(3'd0, 8'h01);
    wr(3'd6, 8'h00);
    rdAddr = 3'd2;
    hit = 0;
    for (int i = 0; i < 1100 && !hit; i++) begin
      tick();
      hit = irqP;
    end
    chk("R6 flagP", irqP, 1);
    chk("R6 wrap", rdData, 0);

    // R8 clear on A, P never even with smaller period
    wr(3'd1, 8'h2C);
    wr(3'd0, 8'h03);
    wr(3'd4, 8'h00);
    wr(3'd5, 8'h02);
    wr(3'd6, 8'h00);
    rdAddr = 3'd3;
    hit = 0;
    for (int i = 0; i < 1100 && !hit; i++) begin
      tick();
      hit = irqA;
    end
    chk("R8 flagA", irqA, 1);
    chk("R8 noP", irqP, 0);
    rdChk("R8 clear", 3'd2, 0);

    // R9 compare zero with clear select 1
    wr(3'd4, 8'h00);
    wr(3'd5, 8'h00);
    wr(3'd6, 8'h00);
    repeat (1100) tick();
    chk("R9 noA", irqA, 0);
    chk("R9 noP", irqP, 0);

    // R4 run off holds count, pin at init level
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h10);
    tick();
    rdChk("R4 cnt", 3'd2, 0);
    chk("R4 pin", outPin, 1);

    // R12 pulse-width placeholder mode
    wr(3'd1, 8'h01);
    wr(3'd4, 8'h10);
    wr(3'd5, 8'h00);
    wr(3'd0, 8'h01);
    wr(3'd6, 8'h00);
    repeat (1100) tick();
    chk("R12 noA", irqA, 0);
    chk("R12 noP", irqP, 0);

    // random phase
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(15) == 0) begin
        logic [2:0] a;
        logic [7:0] d;
        a = 3'($urandom_range(7));
        d = 8'($urandom);
        if (a == 3'd0 && $urandom_range(9) != 0) d[0] = 1'b1;
        if (a == 3'd1 && $urandom_range(3) != 0) d[1:0] = 2'd0;
        wrEn = 1'b1; wrAddr = a; wrData = d;
      end else wrEn = 1'b0;
      rdAddr = 3'($urandom_range(7));
      tick();
    end
    wrEn = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule